// File: doc/BRIEF.md
# Gate Drive Protection Sequencer

This block is the digital core of an isolated gate driver. It turns a complementary pair of control pins into a single drive command. It then sequences three output stages: a strong pull-up, a weak pull-down and a strong pull-down. Each stage gets an explicit dead cycle, so no two stages ever conduct together. The block also enables a Miller clamp switch once the gate is safely low. Every comparator result arrives as a plain digital input: desaturation, gate below the 2 V level, and the two undervoltage flags. All of these are resynchronised inside the block.

After each turn-on, a programmable blanking window masks the desaturation comparator. If the comparator is still asserted once the window has ended, the block trips and latches a fault, and the PWM pins have no further effect. The shutdown is soft: only the weak pull-down acts until the gate comparator reports the gate low, and then the strong pull-down takes over and holds. The active-low fault flag stays low until an active-low clear input is seen low on two consecutive synchronised samples. The sequencer then returns to its off state. A ready flag reports that neither supply side is in undervoltage lockout. Driver-side lockout always keeps the pull-up off.

Top module: `gate_guard_ctrl`

## Requirements
- R1: The drive command is true only when `cmd_pos_i`=1 and `cmd_neg_i`=0; all other combinations give strong pull-down. With the block off and no lockout, `pu_en_o` rises exactly 4 clock cycles after the command becomes true at the pins.
- R2: After `pu_en_o` rises, `desat_i` is ignored for max(`blank_cycles_i`,1) cycles. A desat that is held throughout drops `fault_n_o` exactly `blank_cycles_i`+1 cycles after `pu_en_o` rises. A desat pulse that ends within the window causes no fault.
- R3: On a trip, `fault_n_o` goes low and stays low until a qualified clear.
- R4: While the fault is latched, `pu_en_o` stays 0 whatever the control pins do.
- R5: After a trip, only `pd_weak_o` is driven until `gate_low_i` (synchronised) reports the gate below 2 V. After that, only `pd_strong_o` is driven, and it is held.
- R6: `clamp_o` is 1 only while `pd_strong_o` is 1 and the gate comparator was seen low on the previous cycle; it is never 1 together with `pu_en_o`.
- R7: While `uv_drv_i` is asserted, `pu_en_o` is 0 from the second cycle on. `pd_strong_o` is asserted within 4 cycles, and this holds in the off, on and fault states alike.
- R8: `ready_o` is 1 exactly when both `uv_in_i` and `uv_drv_i` are 0, after 2 synchroniser cycles.
- R9: A clear needs `clr_n_i` low on at least 2 consecutive synchronised samples; a one-sample low pulse leaves the fault latched. A qualified clear returns the block to off, and it re-arms if the command is still true.
- R10: `pu_en_o` is never 1 in the same cycle as either pull-down, and at least one cycle with no stage enabled separates any pull-up cycle from any pull-down cycle.
- R11: If a desat detection and a command release reach the monitoring state in the same cycle, the fault wins: the block trips and latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_pos_i | input | 1 | Non-inverting control pin |
| cmd_neg_i | input | 1 | Inverting control pin |
| clr_n_i | input | 1 | Active-low fault clear |
| desat_i | input | 1 | Desaturation comparator output |
| gate_low_i | input | 1 | Gate below 2 V comparator output |
| uv_in_i | input | 1 | Input-side undervoltage lockout active |
| uv_drv_i | input | 1 | Driver-side undervoltage lockout active |
| blank_cycles_i | input | BLANK_W | Blanking window length in clock cycles |
| pu_en_o | output | 1 | Strong pull-up enable |
| pd_weak_o | output | 1 | Weak (soft shutdown) pull-down enable |
| pd_strong_o | output | 1 | Strong pull-down enable |
| clamp_o | output | 1 | Miller clamp enable |
| fault_n_o | output | 1 | Active-low latched fault flag |
| ready_o | output | 1 | Both supply sides out of lockout |

## Verification
The function collision that matters is a desat detection arriving in the very cycle the command is released. The monitoring state then has two exits: a normal turn-off through a dead cycle, or a trip. The bench provokes the collision by changing `desat_i` and the control pins at the same clock edge, once the blanking window has closed. Both changes then pass through the synchronisers together and reach the sequencer in one cycle. The result is judged from the pins: `fault_n_o` must be low and the pull-up off, rather than a plain return to the off state. A dead-cycle monitor watches the same events to confirm that no pull-down ever follows a pull-up directly.

// File: rtl/gg_pkg.sv
package gg_pkg;

  // Sequencer states; the last three make up the latched fault group.
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,  // strong pull-down held
    ST_ARM   = 3'd1,  // dead cycle before pull-up
    ST_BLANK = 3'd2,  // pull-up, desat masked
    ST_MON   = 3'd3,  // pull-up, desat watched
    ST_GAP   = 3'd4,  // dead cycle before strong pull-down
    ST_TRIP  = 3'd5,  // fault latched, dead cycle
    ST_SOFT  = 3'd6,  // fault, weak pull-down
    ST_HARD  = 3'd7   // fault, strong pull-down held
  } gg_state_e;

  typedef struct packed {
    logic pu;
    logic pd_weak;
    logic pd_strong;
  } gg_drive_t;

  // Bit positions inside the synchroniser bundle.
  localparam int SB_POS    = 0;
  localparam int SB_NEG    = 1;
  localparam int SB_CLR_N  = 2;
  localparam int SB_DESAT  = 3;
  localparam int SB_GLOW   = 4;
  localparam int SB_UV_IN  = 5;
  localparam int SB_UV_DRV = 6;
  localparam int SB_W      = 7;

  // Safe values while in reset: command off, clear idle, both supplies locked out.
  localparam logic [SB_W-1:0] SB_RST = 7'b110_0110;

endpackage

// File: rtl/gg_sync.sv
module gg_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gg_clr_qual.sv
module gg_clr_qual #(
  parameter int SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n_s,
  output logic clr_ok
);

  localparam int CW = $clog2(SAMPLES + 1);
  localparam logic [CW-1:0] NEED = CW'(SAMPLES - 1);

  // Number of consecutive earlier low samples, saturating at NEED.
  logic [CW-1:0] lows;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lows <= '0;
    end else if (clr_n_s) begin
      lows <= '0;
    end else if (lows != NEED) begin
      lows <= lows + 1'b1;
    end
  end

  assign clr_ok = !clr_n_s && (lows == NEED);

endmodule

// File: rtl/gg_blank.sv
module gg_blank #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] limit,
  output logic          done
);

  localparam logic [BW-1:0] ONE = BW'(1);

  logic [BW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= limit;
    end else if (remain > ONE) begin
      remain <= remain - ONE;
    end
  end

  // The final blanking cycle is the one with one count (or none) left.
  assign done = (remain <= ONE);

endmodule

// File: rtl/gg_fsm.sv
module gg_fsm
  import gg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd,
  input  logic      uv_drv,
  input  logic      desat,
  input  logic      gate_low,
  input  logic      clr_ok,
  input  logic      blank_done,
  output logic      blank_load,
  output gg_drive_t drive,
  output logic      fault_n,
  output logic      clamp
);

  gg_state_e st, st_nx;
  logic      clamp_q;
  logic      run_ok;

  assign run_ok = cmd && !uv_drv;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_OFF:   if (run_ok) st_nx = ST_ARM;
      ST_ARM:   st_nx = run_ok ? ST_BLANK : ST_OFF;
      ST_BLANK: begin
        if (!run_ok)         st_nx = ST_GAP;
        else if (blank_done) st_nx = ST_MON;
      end
      ST_MON: begin
        if (uv_drv)     st_nx = ST_GAP;
        else if (desat) st_nx = ST_TRIP;
        else if (!cmd)  st_nx = ST_GAP;
      end
      ST_GAP:   st_nx = ST_OFF;
      ST_TRIP:  st_nx = clr_ok ? ST_OFF : ST_SOFT;
      ST_SOFT: begin
        if (clr_ok)        st_nx = ST_OFF;
        else if (gate_low) st_nx = ST_HARD;
      end
      ST_HARD:  if (clr_ok) st_nx = ST_OFF;
      default:  st_nx = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OFF;
    end else begin
      st <= st_nx;
    end
  end

  always_comb begin
    drive.pu        = ((st == ST_BLANK) || (st == ST_MON)) && !uv_drv;
    drive.pd_weak   = (st == ST_SOFT) && !uv_drv;
    drive.pd_strong = (st == ST_OFF) || (st == ST_HARD) ||
                      ((st == ST_SOFT) && uv_drv);
  end

  assign blank_load = (st == ST_ARM);
  assign fault_n    = !((st == ST_TRIP) || (st == ST_SOFT) || (st == ST_HARD));

  // The clamp follows one cycle after the gate is seen low under strong pull-down.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clamp_q <= 1'b0;
    end else begin
      clamp_q <= drive.pd_strong && gate_low;
    end
  end

  assign clamp = clamp_q && drive.pd_strong;

endmodule

// File: rtl/gate_guard_ctrl.sv
module gate_guard_ctrl
  import gg_pkg::*;
#(
  parameter int BLANK_W     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CLR_SAMPLES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_pos_i,
  input  logic               cmd_neg_i,
  input  logic               clr_n_i,
  input  logic               desat_i,
  input  logic               gate_low_i,
  input  logic               uv_in_i,
  input  logic               uv_drv_i,
  input  logic [BLANK_W-1:0] blank_cycles_i,
  output logic               pu_en_o,
  output logic               pd_weak_o,
  output logic               pd_strong_o,
  output logic               clamp_o,
  output logic               fault_n_o,
  output logic               ready_o
);

  logic [SB_W-1:0] raw_bus, sync_bus;
  logic cmd_s, clr_n_s, desat_s, gate_low_s, uv_in_s, uv_drv_s;
  logic clr_ok, blank_load, blank_done;
  gg_drive_t drive;

  always_comb begin
    raw_bus            = '0;
    raw_bus[SB_POS]    = cmd_pos_i;
    raw_bus[SB_NEG]    = cmd_neg_i;
    raw_bus[SB_CLR_N]  = clr_n_i;
    raw_bus[SB_DESAT]  = desat_i;
    raw_bus[SB_GLOW]   = gate_low_i;
    raw_bus[SB_UV_IN]  = uv_in_i;
    raw_bus[SB_UV_DRV] = uv_drv_i;
  end

  gg_sync #(
    .W       (SB_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SB_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_bus),
    .q     (sync_bus)
  );

  // Complementary decode: only positive-high with negative-low commands drive.
  assign cmd_s      = sync_bus[SB_POS] && !sync_bus[SB_NEG];
  assign clr_n_s    = sync_bus[SB_CLR_N];
  assign desat_s    = sync_bus[SB_DESAT];
  assign gate_low_s = sync_bus[SB_GLOW];
  assign uv_in_s    = sync_bus[SB_UV_IN];
  assign uv_drv_s   = sync_bus[SB_UV_DRV];

  gg_clr_qual #(
    .SAMPLES (CLR_SAMPLES)
  ) u_clr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n_s (clr_n_s),
    .clr_ok  (clr_ok)
  );

  gg_blank #(
    .BW (BLANK_W)
  ) u_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (blank_load),
    .limit (blank_cycles_i),
    .done  (blank_done)
  );

  gg_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd_s),
    .uv_drv     (uv_drv_s),
    .desat      (desat_s),
    .gate_low   (gate_low_s),
    .clr_ok     (clr_ok),
    .blank_done (blank_done),
    .blank_load (blank_load),
    .drive      (drive),
    .fault_n    (fault_n_o),
    .clamp      (clamp_o)
  );

  assign pu_en_o     = drive.pu;
  assign pd_weak_o   = drive.pd_weak;
  assign pd_strong_o = drive.pd_strong;
  assign ready_o     = !uv_in_s && !uv_drv_s;

endmodule

// File: rtl/gate_guard_chk.sv
module gate_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_pos_i,
  input logic cmd_neg_i,
  input logic uv_in_i,
  input logic uv_drv_i,
  input logic pu_en_o,
  input logic pd_weak_o,
  input logic pd_strong_o,
  input logic clamp_o,
  input logic fault_n_o,
  input logic ready_o,
  input logic clr_ok,
  input logic gate_low_s,
  input logic uv_drv_s
);

  // Cycles since reset release, saturating; keeps $past windows inside that span.
  logic [2:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  AST_CMD_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd3 && pu_en_o) |-> ($past(cmd_pos_i, 3) && !$past(cmd_neg_i, 3))); // R1

  AST_FLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n_o && !clr_ok) |=> !fault_n_o); // R3

  AST_FLT_NO_PU: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n_o |-> !pu_en_o); // R4

  AST_SOFT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fault_n_o) && !clr_ok) |=> ((pd_weak_o || pd_strong_o) && !pu_en_o)); // R5

  AST_HARD_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pd_strong_o) && !fault_n_o && !uv_drv_s) |-> $past(gate_low_s)); // R5

  AST_CLAMP_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_o |-> (pd_strong_o && !pu_en_o && $past(gate_low_s))); // R6

  AST_UV_NO_PU: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd2 && $past(uv_drv_i, 2)) |-> !pu_en_o); // R7

  AST_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd2) |-> (ready_o == (!$past(uv_in_i, 2) && !$past(uv_drv_i, 2)))); // R8

  AST_CLR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n_o && clr_ok) |=> fault_n_o); // R9

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(pu_en_o && (pd_weak_o || pd_strong_o))); // R10

  AST_DEAD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pu_en_o) |-> (!pd_weak_o && !pd_strong_o)); // R10

  AST_DEAD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pu_en_o) |-> ($past(!pd_weak_o) && $past(!pd_strong_o))); // R10

endmodule

bind gate_guard_ctrl gate_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_pos_i   (cmd_pos_i),
  .cmd_neg_i   (cmd_neg_i),
  .uv_in_i     (uv_in_i),
  .uv_drv_i    (uv_drv_i),
  .pu_en_o     (pu_en_o),
  .pd_weak_o   (pd_weak_o),
  .pd_strong_o (pd_strong_o),
  .clamp_o     (clamp_o),
  .fault_n_o   (fault_n_o),
  .ready_o     (ready_o),
  .clr_ok      (clr_ok),
  .gate_low_s  (gate_low_s),
  .uv_drv_s    (uv_drv_s)
);

// File: tb/gate_guard_ctrl_tb.sv
module gate_guard_ctrl_tb;

  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pos, neg, clr_n, desat, glow, uvi, uvd;
  logic [BW-1:0] blank;
  logic pu, pdw, pds, clamp, fault_n, ready;

  int n_chk = 0;
  int n_fail = 0;
  int dead_bad = 0;
  logic prev_pu = 1'b0;
  logic prev_pd = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gate_guard_ctrl #(.BLANK_W(BW)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_pos_i      (pos),
    .cmd_neg_i      (neg),
    .clr_n_i        (clr_n),
    .desat_i        (desat),
    .gate_low_i     (glow),
    .uv_in_i        (uvi),
    .uv_drv_i       (uvd),
    .blank_cycles_i (blank),
    .pu_en_o        (pu),
    .pd_weak_o      (pdw),
    .pd_strong_o    (pds),
    .clamp_o        (clamp),
    .fault_n_o      (fault_n),
    .ready_o        (ready)
  );

  // Vector fields: {pos, neg, uv_in, uv_drv, exp_pu, exp_pd_strong, exp_ready}
  localparam logic [6:0] VEC [9] = '{
    7'b1000_101,
    7'b1100_011,
    7'b0000_011,
    7'b0100_011,
    7'b1000_101,
    7'b1010_100,
    7'b1001_010,
    7'b1000_101,
    7'b0011_010
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pu();
    for (int i = 0; i < 60 && !pu; i++) tick(1);
  endtask

  task automatic wait_fault();
    for (int i = 0; i < 80 && fault_n; i++) tick(1);
  endtask

  task automatic do_clear(input int len);
    clr_n = 1'b0;
    tick(len);
    clr_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Dead-cycle monitor (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (pu && (pdw || pds)) dead_bad++;
      if (prev_pu && (pdw || pds)) dead_bad++;
      if (prev_pd && pu) dead_bad++;
    end
    prev_pu = pu;
    prev_pd = pdw || pds;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int cnt;
    pos = 0; neg = 0; clr_n = 1; desat = 0; glow = 0; uvi = 1; uvd = 1;
    blank = 8'd3;
    tick(3);
    chk("R1 reset pu", pu, 0);
    chk("R7 reset pd_strong", pds, 1);
    chk("R3 reset fault_n", fault_n, 1);
    chk("R8 reset ready", ready, 0);
    chk("R6 reset clamp", clamp, 0);
    rst_n = 1'b1;
    uvi = 0; uvd = 0; glow = 1;
    tick(10);

    // Table walk: decode, lockout and ready (R1, R7, R8, R6)
    foreach (VEC[i]) begin
      {pos, neg, uvi, uvd} = VEC[i][6:3];
      tick(10);
      chk($sformatf("R1 vec%0d pu", i), pu, VEC[i][2]);
      chk($sformatf("R7 vec%0d pd_strong", i), pds, VEC[i][1]);
      chk($sformatf("R8 vec%0d ready", i), ready, VEC[i][0]);
      chk($sformatf("R6 vec%0d clamp", i), clamp, VEC[i][1]);
      chk($sformatf("R5 vec%0d pd_weak", i), pdw, 0);
    end
    pos = 0; uvi = 0; uvd = 0;
    tick(10);

    // Blanking length with desat held (R2)
    blank = 8'd5; glow = 0; desat = 1; pos = 1;
    wait_pu();
    cnt = 0;
    while (fault_n && cnt < 40) begin tick(1); cnt++; end
    chk("R2 cycles from pull-up to trip", cnt, 6);
    chk("R3 fault flag low", fault_n, 0);
    desat = 0;

    // Soft shutdown phase and ignored inputs (R5, R4)
    tick(4);
    chk("R5 soft weak pd", pdw, 1);
    chk("R5 soft no strong pd", pds, 0);
    for (int k = 0; k < 3; k++) begin
      pos = ~pos; tick(4);
      chk("R4 pu while faulted", pu, 0);
      chk("R3 fault held", fault_n, 0);
    end
    pos = 1;
    glow = 1;
    tick(5);
    chk("R5 hard strong pd", pds, 1);
    chk("R5 hard weak off", pdw, 0);
    chk("R6 clamp after gate low", clamp, 1);
    chk("R4 pu held off", pu, 0);
    pos = 0;

    // Clear qualification (R9)
    do_clear(1);
    tick(6);
    chk("R9 short clear ignored", fault_n, 0);
    do_clear(3);
    tick(4);
    chk("R9 qualified clear", fault_n, 1);
    chk("R9 back to off", pds, 1);
    tick(6);

    // Turn-on latency and driver lockout while on (R1, R7)
    glow = 0; pos = 1;
    tick(3);
    chk("R1 pu not yet", pu, 0);
    tick(1);
    chk("R1 pu after 4 cycles", pu, 1);
    tick(10);
    uvd = 1;
    tick(3);
    chk("R7 pu cut by lockout", pu, 0);
    tick(3);
    chk("R7 strong pd under lockout", pds, 1);
    chk("R8 ready low under lockout", ready, 0);
    uvd = 0;
    tick(12);
    chk("R7 pu back after lockout", pu, 1);

    // Short desat pulse inside blanking (R2)
    pos = 0; tick(8);
    blank = 8'd20; pos = 1;
    wait_pu();
    desat = 1; tick(5); desat = 0;
    tick(40);
    chk("R2 masked pulse fault_n", fault_n, 1);
    chk("R2 masked pulse pu", pu, 1);

    // Desat and command release in the same cycle (R11)
    desat = 1; pos = 0;
    tick(8);
    chk("R11 fault wins", fault_n, 0);
    chk("R11 pu off", pu, 0);
    desat = 0;
    do_clear(3);
    tick(6);
    chk("R9 cleared after collision", fault_n, 1);

    // Lockout during soft shutdown, then clear with command held (R7, R9)
    blank = 8'd2; glow = 0; desat = 1; pos = 1;
    wait_fault();
    tick(4);
    chk("R5 soft before lockout", pdw, 1);
    uvd = 1;
    tick(4);
    chk("R7 strong pd in fault lockout", pds, 1);
    chk("R7 weak off in fault lockout", pdw, 0);
    chk("R8 ready low in fault lockout", ready, 0);
    uvd = 0; desat = 0;
    tick(4);
    do_clear(3);
    tick(12);
    chk("R9 cleared with command high", fault_n, 1);
    chk("R9 re-armed", pu, 1);

    chk("R10 dead-cycle violations", dead_bad, 0);
    finish_run();
  end

endmodule